// File: doc/BRIEF.md
# Masked Local-Bus Interrupt Encoder

This block gathers sixteen level-sensitive interrupt request lines from peripherals on a local bus and presents them to a processor as one combined interrupt. Each request line passes through a two-flop synchroniser. The synchronised level is the status bit for that source, so it tracks the line with no latching. A software-writable enable mask picks which status bits count as pending. The combined interrupt output is high while any pending bit is set.

Software reaches the block through a 16-bit register port. The vector register reports which source to service, encoded as (index of the lowest-numbered pending source + 1) shifted left by two. A read value of zero therefore means that nothing is pending. A second register holds the enable mask and can be read and written. The block has no acknowledge cycle: a source stops interrupting once its peripheral drops its request line.

Top module: `lbirq_encoder`

## Requirements
- R1: After reset the enable mask reads 0x0010, every status bit is zero, the combined interrupt is low and the vector register reads 0.
- R2: A status bit goes high two clock edges after its request line goes high and goes low two clock edges after the line goes low. After only one edge it still holds its old value.
- R3: The combined interrupt output is high exactly when at least one status bit is set whose enable-mask bit is also set.
- R4: A read at byte offset 0x00 returns (n + 1) << 2, where n is the lowest index whose status and mask bits are both set. Lower indices take priority over higher ones.
- R5: The vector read at offset 0x00 is 0 when no source is pending, and this includes the case where requests are active but all are masked.
- R6: Byte offset 0x02 holds the 16-bit enable mask (bit i enables source i). A write stores all 16 bits and a read at that offset returns them.
- R7: A mask write changes the pending set and the combined output on the clock edge that performs the write, with no synchroniser delay.
- R8: Reads at any offset other than 0x00 and 0x02 return 0. Writes to any offset other than 0x02 leave the mask, the vector and the combined output unchanged. This includes writes to offset 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | 16 | Level request lines, bit i is source i |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wen | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
The status-tracking property assumes that the request lines are quiet while reset is held, because it compares each status bit with the request level two edges earlier and starts only once two edges have passed outside reset. The bench holds every request line low through reset. It changes requests, addresses and write strobes only on the falling clock edge, so no input changes at a sampling edge. The mask-write properties assume that a write strobe lasts exactly one cycle with stable address and data, and the bench's write task drives each write that way.

// File: rtl/lbirq_pkg.sv
// Package lbirq_pkg
// Shared register offsets and reset values for the masked interrupt encoder.
// Assumes byte addressing with 16-bit registers.
package lbirq_pkg;
    localparam int unsigned LB_DATA_W   = 16;
    localparam int unsigned LB_ADDR_W   = 12;
    localparam logic [LB_ADDR_W-1:0] OFF_VECTOR = 12'h000;
    localparam logic [LB_ADDR_W-1:0] OFF_ENABLE = 12'h002;
    localparam logic [LB_DATA_W-1:0] ENABLE_RST = 16'h0010;
    localparam int unsigned VEC_SHIFT   = 2;
endpackage

// File: rtl/lbirq_sync.sv
// Module lbirq_sync
// Two-flop synchroniser per request line. The second stage is the status
// bit for that source. Assumes request lines are asynchronous level signals.
module lbirq_sync #(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_async,
    output logic [NUM_SRC-1:0] req_level
);
    logic [NUM_SRC-1:0] meta_q;
    logic [NUM_SRC-1:0] level_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
        // Purpose: move one request line into the clock domain in two stages.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[g]  <= 1'b0;
                level_q[g] <= 1'b0;
            end else begin
                meta_q[g]  <= req_async[g];
                level_q[g] <= meta_q[g];
            end
        end
    end

    assign req_level = level_q;
endmodule

// File: rtl/lbirq_prienc.sv
// Module lbirq_prienc
// Combinational priority encoder: gives the lowest set index of the input
// and a flag saying whether any bit is set. Pure logic, no state.
module lbirq_prienc #(
    parameter int unsigned NUM_SRC = 16,
    localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] pend,
    output logic               any_set,
    output logic [IDX_W-1:0]   low_idx
);
    // Purpose: scan from the top down so the lowest set bit is written last.
    always_comb begin
        low_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) low_idx = IDX_W'(i);
        end
    end

    assign any_set = |pend;
endmodule

// File: rtl/lbirq_regs.sv
// Module lbirq_regs
// Register file: the enable mask (read/write) and the vector register
// (read only), decoded from a byte offset. Reads are combinational.
// Accesses at any other offset read zero and write nothing.
module lbirq_regs
    import lbirq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LB_ADDR_W-1:0]  addr,
    input  logic                  wen,
    input  logic [LB_DATA_W-1:0]  wdata,
    input  logic                  any_pend,
    input  logic [IDX_W-1:0]      low_idx,
    output logic [NUM_SRC-1:0]    mask,
    output logic [LB_DATA_W-1:0]  vector,
    output logic [LB_DATA_W-1:0]  rdata
);
    logic [NUM_SRC-1:0] mask_q;

    // Purpose: hold the enable mask, loaded only by a write at its offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= NUM_SRC'(ENABLE_RST);
        end else if (wen && (addr == OFF_ENABLE)) begin
            mask_q <= wdata[NUM_SRC-1:0];
        end
    end

    // Purpose: form the service vector, (index + 1) << shift, or zero.
    always_comb begin
        if (any_pend) begin
            vector = (LB_DATA_W'(low_idx) + LB_DATA_W'(1)) << VEC_SHIFT;
        end else begin
            vector = '0;
        end
    end

    // Purpose: read-data multiplexer by offset.
    always_comb begin
        case (addr)
            OFF_VECTOR: rdata = vector;
            OFF_ENABLE: rdata = LB_DATA_W'(mask_q);
            default:    rdata = '0;
        endcase
    end

    assign mask = mask_q;
endmodule

// File: rtl/lbirq_encoder.sv
// Module lbirq_encoder (top)
// Masked local-bus interrupt encoder: synchronises the request levels, masks
// them, drives one combined interrupt and reports the lowest pending source.
// Assumes NUM_SRC <= 16 so the mask fits the 16-bit register.
module lbirq_encoder
    import lbirq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   irq_req,
    input  logic [LB_ADDR_W-1:0] reg_addr,
    input  logic                 reg_wen,
    input  logic [LB_DATA_W-1:0] reg_wdata,
    output logic [LB_DATA_W-1:0] reg_rdata,
    output logic                 irq_out
);
    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0]   status;
    logic [NUM_SRC-1:0]   mask;
    logic [NUM_SRC-1:0]   pending;
    logic                 any_pend;
    logic [IDX_W-1:0]     low_idx;
    logic [LB_DATA_W-1:0] vector;

    lbirq_sync #(.NUM_SRC(NUM_SRC)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_async (irq_req),
        .req_level (status)
    );

    assign pending = status & mask;

    lbirq_prienc #(.NUM_SRC(NUM_SRC)) u_prienc (
        .pend    (pending),
        .any_set (any_pend),
        .low_idx (low_idx)
    );

    lbirq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (reg_addr),
        .wen      (reg_wen),
        .wdata    (reg_wdata),
        .any_pend (any_pend),
        .low_idx  (low_idx),
        .mask     (mask),
        .vector   (vector),
        .rdata    (reg_rdata)
    );

    assign irq_out = any_pend;
endmodule

// File: rtl/lbirq_encoder_chk.sv
// Module lbirq_encoder_chk
// Property checker bound into lbirq_encoder. Assumes request lines are low
// during reset and that write strobes are single-cycle.
module lbirq_encoder_chk
    import lbirq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SRC-1:0]   irq_req,
    input logic [LB_ADDR_W-1:0] reg_addr,
    input logic                 reg_wen,
    input logic [LB_DATA_W-1:0] reg_wdata,
    input logic                 irq_out,
    input logic [NUM_SRC-1:0]   status,
    input logic [NUM_SRC-1:0]   mask,
    input logic [LB_DATA_W-1:0] vector
);
    logic [1:0] since_rst;

    // Purpose: count edges since reset, saturating, to guard $past depth.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_RESET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd1) |-> (mask == NUM_SRC'(ENABLE_RST))); // R1

    AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (status == $past(irq_req, 2))); // R2

    AST_OUT_VS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (vector != '0)); // R3

    AST_VECTOR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (vector[1:0] == 2'b00) && (vector <= LB_DATA_W'(NUM_SRC << VEC_SHIFT))); // R4

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == OFF_ENABLE) |=> (mask == $past(reg_wdata[NUM_SRC-1:0]))); // R6

    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wen && reg_addr == OFF_ENABLE) |=> $stable(mask)); // R8
endmodule

bind lbirq_encoder lbirq_encoder_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .reg_addr  (reg_addr),
    .reg_wen   (reg_wen),
    .reg_wdata (reg_wdata),
    .irq_out   (irq_out),
    .status    (status),
    .mask      (mask),
    .vector    (vector)
);

// File: tb/test_lbirq_encoder.sv
`timescale 1ns/1ps
module test_lbirq_encoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_req = '0;
    logic [11:0] reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] exp_mask = 16'h0010;

    always #2.5 clk = ~clk;

    lbirq_encoder i_lbirq_encoder (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_addr(reg_addr),
        .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    function automatic logic [15:0] model_vec(input logic [15:0] st, input logic [15:0] mk);
        logic [15:0] p = st & mk;
        for (int i = 0; i < 16; i++) if (p[i]) return 16'((i + 1) * 4);
        return 16'h0;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
        if (a == 12'h002) exp_mask = d;
    endtask

    task automatic set_req(input logic [15:0] v);
        irq_req = v; cyc(2);
    endtask

    task automatic check_state(input string tag);
        logic [15:0] d;
        rd(12'h000, d);
        check({tag, " vector"}, d, model_vec(irq_req, exp_mask));
        check({tag, " irq_out"}, {15'd0, irq_out}, {15'd0, model_vec(irq_req, exp_mask) != 0});
    endtask

    task automatic t_reset;
        logic [15:0] d;
        rd(12'h002, d); check("R1 mask reset", d, 16'h0010);
        rd(12'h000, d); check("R1 vector reset", d, 16'h0000);
        check("R1 irq_out reset", {15'd0, irq_out}, 16'h0);
    endtask

    task automatic t_latency;
        irq_req = 16'h0010;
        cyc(1);
        check("R2 not yet set after one edge", {15'd0, irq_out}, 16'h0);
        cyc(1);
        check("R2 set after two edges", {15'd0, irq_out}, 16'h1);
        check_state("R4 enabled source 4");
        irq_req = 16'h0000;
        cyc(1);
        check("R2 still set one edge after drop", {15'd0, irq_out}, 16'h1);
        cyc(1);
        check("R2 cleared after two edges", {15'd0, irq_out}, 16'h0);
    endtask

    task automatic t_priority;
        wr(12'h002, 16'hFFFF);
        set_req(16'h8000); check_state("R4 top source 15");
        set_req(16'h8421); check_state("R4 lowest of several (0)");
        set_req(16'h8420); check_state("R4 lowest of several (5)");
        set_req(16'h0002); check_state("R4 source 1");
        set_req(16'h0000); check_state("R5 none pending");
    endtask

    task automatic t_masked;
        wr(12'h002, 16'h00F0);
        set_req(16'h0F0F); check_state("R5 all active masked");
        check("R3 masked irq low", {15'd0, irq_out}, 16'h0);
        set_req(16'h0F4F); check_state("R3 one enabled source 6");
    endtask

    task automatic t_mask_rw;
        logic [15:0] d;
        wr(12'h002, 16'hA5C3);
        rd(12'h002, d); check("R6 mask readback A5C3", d, 16'hA5C3);
        wr(12'h002, 16'h0000);
        rd(12'h002, d); check("R6 mask readback 0000", d, 16'h0000);
    endtask

    task automatic t_mask_immediate;
        irq_req = 16'h0300; cyc(3);
        wr(12'h002, 16'h0000);
        check("R7 no pending with mask 0", {15'd0, irq_out}, 16'h0);
        reg_addr = 12'h002; reg_wdata = 16'h0200; reg_wen = 1'b1;
        @(posedge clk); #1;
        reg_wen = 1'b0; exp_mask = 16'h0200;
        check("R7 irq high right after write edge", {15'd0, irq_out}, 16'h1);
        @(negedge clk);
        check_state("R7 vector for source 9");
    endtask

    task automatic t_bad_offsets;
        logic [15:0] d;
        rd(12'h004, d); check("R8 read 0x004", d, 16'h0);
        rd(12'h001, d); check("R8 read 0x001", d, 16'h0);
        rd(12'hFFE, d); check("R8 read 0xFFE", d, 16'h0);
        wr(12'h000, 16'hFFFF);
        rd(12'h002, d); check("R8 write to 0x000 ignored", d, 16'h0200);
        check_state("R8 vector after ignored write");
        wr(12'h012, 16'h0000);
        wr(12'h003, 16'h0000);
        rd(12'h002, d); check("R8 writes elsewhere ignored", d, 16'h0200);
        check("R8 irq unchanged", {15'd0, irq_out}, 16'h1);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        cyc(3);
        t_reset();
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_latency();
        t_priority();
        t_masked();
        t_mask_rw();
        t_mask_immediate();
        t_bad_offsets();
        cyc(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule